// File: doc/BRIEF.md
# Byte-Port Configuration Loader

This block is the device-side engine behind a byte-wide microprocessor port that loads a configuration image. A register-select input steers each host write. With select low the byte is a command: soft reset, start load, or switch on the analog section and bootstrap supply. With select high the byte is configuration data, and a read returns a status byte.

In load mode, data bytes shift into a shift register one row wide. When the row is full the engine copies it into the next row of a modelled configuration memory over a fixed number of clocks. During that copy `busy_o` is high. At every other time bytes are taken back to back at one per clock. The row pointer steps after each copy. When the last row has been written, the engine reports done and leaves load mode.

Top module: `cfg_loader`

## Requirements
- R1: After `rst_ni` is released, the status byte is 0x00, `busy_o`, `analog_en_o` and `boot_en_o` are 0, and every bit of `row_valid_o` is 0.
- R2: A write of CMD_RST (0x01) with `sel_i`=0 acts like a hardware reset from the next cycle. Status returns to 0x00, all row valid flags clear, and the analog and bootstrap enables clear.
- R3: A write of CMD_LOAD (0x02) with `sel_i`=0 sets status bit 1 (load mode). It also restarts the row pointer at row 0, empties the shift register and clears the done bit.
- R4: In load mode, a write with `sel_i`=1 shifts the byte into the row register, so the first byte of a row ends up in the top byte of the stored row. The cycle after the ROW_BYTES-th byte is taken, `busy_o` goes high for exactly COPY_CYC cycles. At the falling edge of `busy_o` the row is in memory at the current pointer and its valid flag is set.
- R5: Outside the row copy, `busy_o` stays low and data writes on consecutive clocks are all accepted. A complete image written at one byte per clock, pausing only while busy, lands unchanged in memory.
- R6: A data write while `busy_o` is high is dropped and does not enter the row register. It sets the overrun bit (status bit 3), which stays set until a hardware or command reset.
- R7: When row ROWS-1 is committed, the done bit (status bit 2) sets and load mode (bit 1) clears. After that, data writes have no effect.
- R8: A write of CMD_ANA (0x10) with `sel_i`=0 sets `analog_en_o`, `boot_en_o` and status bit 4. Any other command value changes nothing.
- R9: With `sel_i`=1, `rdata_o` is the status byte: bit 0 busy, bit 1 load mode, bit 2 done, bit 3 overrun, bit 4 analog enabled, bits 7..5 zero. With `sel_i`=0, `rdata_o` is 0x00.
- R10: A data write while not in load mode is ignored. Status, row valid flags and the bytes of the next loaded row are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register select: 0 command, 1 data/status |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte (status when sel_i=1) |
| busy_o | output | 1 | Row copy in progress, data cannot be taken |
| analog_en_o | output | 1 | Analog section enable flag |
| boot_en_o | output | 1 | Bootstrap supply enable flag |
| mem_raddr_i | input | $clog2(ROWS) | Configuration memory row read address |
| mem_rdata_o | output | ROW_BYTES*8 | Configuration memory row contents |
| row_valid_o | output | ROWS | Per-row written flags |

## Verification
On every cycle, the assertions check the following. The busy window never runs longer than COPY_CYC cycles, and it lasts exactly that long unless a command cuts it short. A write during busy always leaves overrun set, and overrun cannot clear without a reset command. Valid flags grow by at most one row per cycle, and done never coexists with load mode. Only the directed scenarios can show the rest: the byte order within stored rows, that a dropped or out-of-mode byte leaves the next row's contents untouched, that a whole image lands in order with done, and the effects of the command values.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_SOFT_RST,
    CMD_START_LOAD,
    CMD_ANALOG_ON
  } cmd_e;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       analog;
    logic       overrun;
    logic       done;
    logic       load;
    logic       busy;
  } status_t;

endpackage

// File: rtl/cfg_cmd_dec.sv
module cfg_cmd_dec
  import cfg_loader_pkg::*;
#(
  parameter logic [7:0] CMD_RST  = 8'h01,
  parameter logic [7:0] CMD_LOAD = 8'h02,
  parameter logic [7:0] CMD_ANA  = 8'h10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output cmd_e       cmd_o,
  output logic       data_wr_o,
  output logic       analog_o,
  output logic       boot_o
);

  logic analog_q, boot_q;

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i && !sel_i) begin
      unique case (wdata_i)
        CMD_RST:  cmd_o = CMD_SOFT_RST;
        CMD_LOAD: cmd_o = CMD_START_LOAD;
        CMD_ANA:  cmd_o = CMD_ANALOG_ON;
        default:  cmd_o = CMD_NONE;
      endcase
    end
  end

  assign data_wr_o = wr_i && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      analog_q <= 1'b0;
      boot_q   <= 1'b0;
    end else if (cmd_o == CMD_SOFT_RST) begin
      analog_q <= 1'b0;
      boot_q   <= 1'b0;
    end else if (cmd_o == CMD_ANALOG_ON) begin
      analog_q <= 1'b1;
      boot_q   <= 1'b1;
    end
  end

  assign analog_o = analog_q;
  assign boot_o   = boot_q;

endmodule

// File: rtl/cfg_row_shift.sv
module cfg_row_shift #(
  parameter int ROW_BYTES = 32,
  localparam int RowBits  = ROW_BYTES * 8,
  localparam int CntW     = $clog2(ROW_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               push_i,
  input  logic [7:0]         byte_i,
  output logic               full_o,
  output logic [RowBits-1:0] row_o
);

  logic [RowBits-1:0] sreg_q;
  logic [CntW-1:0]    cnt_q;

  assign full_o = push_i && (cnt_q == CntW'(ROW_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (push_i) begin
      // first byte of a row migrates to the top
      sreg_q <= {sreg_q[RowBits-9:0], byte_i};
      cnt_q  <= full_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign row_o = sreg_q;

endmodule

// File: rtl/cfg_copy_ctrl.sv
module cfg_copy_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COPY_CYC = 8,
  localparam int PtrW    = $clog2(ROWS),
  localparam int TmrW    = $clog2(COPY_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_e            cmd_i,
  input  logic            data_wr_i,
  input  logic            row_full_i,
  output logic            accept_o,
  output logic            commit_o,
  output logic [PtrW-1:0] ptr_o,
  output logic            busy_o,
  output logic            load_o,
  output logic            done_o,
  output logic            overrun_o
);

  logic            load_q, busy_q, done_q, ovr_q;
  logic [TmrW-1:0] tmr_q;
  logic [PtrW-1:0] ptr_q;
  logic            last_tick;

  assign accept_o  = data_wr_i && load_q && !busy_q;
  assign last_tick = busy_q && (tmr_q == '0);
  assign commit_o  = last_tick && (cmd_i != CMD_SOFT_RST) && (cmd_i != CMD_START_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      tmr_q  <= '0;
      ptr_q  <= '0;
    end else if (cmd_i == CMD_SOFT_RST) begin
      load_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      tmr_q  <= '0;
      ptr_q  <= '0;
    end else if (cmd_i == CMD_START_LOAD) begin
      load_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tmr_q  <= '0;
      ptr_q  <= '0;
    end else begin
      if (data_wr_i && busy_q) ovr_q <= 1'b1;
      if (row_full_i) begin
        busy_q <= 1'b1;
        tmr_q  <= TmrW'(COPY_CYC - 1);
      end else if (last_tick) begin
        busy_q <= 1'b0;
        ptr_q  <= (ptr_q == PtrW'(ROWS - 1)) ? '0 : ptr_q + 1'b1;
        if (ptr_q == PtrW'(ROWS - 1)) begin
          done_q <= 1'b1;
          load_q <= 1'b0;
        end
      end else if (busy_q) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign busy_o    = busy_q;
  assign load_o    = load_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 32,
  localparam int RowBits  = ROW_BYTES * 8,
  localparam int PtrW     = $clog2(ROWS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [PtrW-1:0]    waddr_i,
  input  logic [RowBits-1:0] wdata_i,
  input  logic [PtrW-1:0]    raddr_i,
  output logic [RowBits-1:0] rdata_o,
  output logic [ROWS-1:0]    valid_o
);

  logic [RowBits-1:0] mem_q [ROWS];
  logic [ROWS-1:0]    valid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_valid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              valid_q[g] <= 1'b0;
      else if (clr_i)                           valid_q[g] <= 1'b0;
      else if (we_i && waddr_i == PtrW'(g))     valid_q[g] <= 1'b1;
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign valid_o = valid_q;

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int         ROW_BYTES = 32,
  parameter int         ROWS      = 16,
  parameter int         COPY_CYC  = 8,
  parameter logic [7:0] CMD_RST   = 8'h01,
  parameter logic [7:0] CMD_LOAD  = 8'h02,
  parameter logic [7:0] CMD_ANA   = 8'h10,
  localparam int        RowBits   = ROW_BYTES * 8,
  localparam int        PtrW      = $clog2(ROWS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               busy_o,
  output logic               analog_en_o,
  output logic               boot_en_o,
  input  logic [PtrW-1:0]    mem_raddr_i,
  output logic [RowBits-1:0] mem_rdata_o,
  output logic [ROWS-1:0]    row_valid_o
);

  cmd_e               cmd;
  logic               data_wr, accept, full, commit;
  logic               busy, load, done, ovr, analog;
  logic [PtrW-1:0]    ptr;
  logic [RowBits-1:0] row;
  status_t            status;

  cfg_cmd_dec #(
    .CMD_RST (CMD_RST),
    .CMD_LOAD(CMD_LOAD),
    .CMD_ANA (CMD_ANA)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .cmd_o    (cmd),
    .data_wr_o(data_wr),
    .analog_o (analog),
    .boot_o   (boot_en_o)
  );

  cfg_row_shift #(.ROW_BYTES(ROW_BYTES)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd == CMD_SOFT_RST || cmd == CMD_START_LOAD),
    .push_i(accept),
    .byte_i(wdata_i),
    .full_o(full),
    .row_o (row)
  );

  cfg_copy_ctrl #(.ROWS(ROWS), .COPY_CYC(COPY_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .data_wr_i (data_wr),
    .row_full_i(full),
    .accept_o  (accept),
    .commit_o  (commit),
    .ptr_o     (ptr),
    .busy_o    (busy),
    .load_o    (load),
    .done_o    (done),
    .overrun_o (ovr)
  );

  cfg_mem #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd == CMD_SOFT_RST),
    .we_i   (commit),
    .waddr_i(ptr),
    .wdata_i(row),
    .raddr_i(mem_raddr_i),
    .rdata_o(mem_rdata_o),
    .valid_o(row_valid_o)
  );

  always_comb begin
    status         = '0;
    status.busy    = busy;
    status.load    = load;
    status.done    = done;
    status.overrun = ovr;
    status.analog  = analog;
  end

  assign rdata_o     = sel_i ? status : 8'h00;
  assign busy_o      = busy;
  assign analog_en_o = analog;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int         ROWS     = 16,
  parameter int         COPY_CYC = 8,
  parameter logic [7:0] CMD_RST  = 8'h01
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sel_i,
  input logic            wr_i,
  input logic [7:0]      wdata_i,
  input logic [7:0]      rdata_o,
  input logic            busy_o,
  input logic            analog_en_o,
  input logic            boot_en_o,
  input logic [ROWS-1:0] row_valid_o
);

  logic [31:0] bcnt_q;
  logic        soft_rst;
  logic [7:0]  stat;

  assign soft_rst = wr_i && !sel_i && (wdata_i == CMD_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= '0;
    else if (busy_o) bcnt_q <= bcnt_q + 1;
    else             bcnt_q <= '0;
  end

  // status is sampled through the port with sel_i high only
  assign stat = rdata_o;

  p_busy_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt_q < COPY_CYC);

  p_busy_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(wr_i && !sel_i)) |-> $past(bcnt_q) == COPY_CYC - 1);

  p_drop_sets_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i && sel_i) |=> (!sel_i || stat[3]));

  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && stat[3] && !soft_rst) |=> (!sel_i || stat[3]));

  p_valid_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(row_valid_o) <= $countones($past(row_valid_o)) + 1);

  p_soft_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (row_valid_o == '0 && !busy_o && !analog_en_o && !boot_en_o));

  p_done_not_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && stat[2]) |-> !stat[1]);

  p_sel_low_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> rdata_o == 8'h00);

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> rdata_o[7:5] == 3'b000);

  p_busy_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> rdata_o[0] == busy_o);

endmodule

bind cfg_loader cfg_loader_chk #(
  .ROWS    (ROWS),
  .COPY_CYC(COPY_CYC),
  .CMD_RST (CMD_RST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .busy_o     (busy_o),
  .analog_en_o(analog_en_o),
  .boot_en_o  (boot_en_o),
  .row_valid_o(row_valid_o)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;

  localparam int RB   = 32;
  localparam int NR   = 16;
  localparam int CC   = 8;
  localparam int RBIT = RB * 8;
  localparam int PW   = $clog2(NR);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sel = 1'b0, wr = 1'b0;
  logic [7:0]      wdata = 8'h00;
  logic [7:0]      rdata;
  logic            busy, ana, boot;
  logic [PW-1:0]   raddr = '0;
  logic [RBIT-1:0] rrow;
  logic [NR-1:0]   valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_loader u_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .analog_en_o(ana), .boot_en_o(boot),
    .mem_raddr_i(raddr), .mem_rdata_o(rrow), .row_valid_o(valid)
  );

  task automatic check(string req, logic [RBIT-1:0] act, logic [RBIT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int r, int i, int seed);
    return 8'((r * 37) + (i * 5) + 3 + seed);
  endfunction

  function automatic logic [RBIT-1:0] exp_row(int r, int seed);
    logic [RBIT-1:0] v = '0;
    for (int i = 0; i < RB; i++) v = {v[RBIT-9:0], pat(r, i, seed)};
    return v;
  endfunction

  task automatic status(output logic [7:0] s);
    sel = 1'b1;
    #0.1 s = rdata;
  endtask

  task automatic cmd(logic [7:0] c);
    @(negedge clk);
    sel = 1'b0; wr = 1'b1; wdata = c;
    @(negedge clk);
    wr = 1'b0; sel = 1'b1;
  endtask

  // one byte per clock; leaves the bench at the negedge after the last write
  task automatic push_row(int r, int seed);
    for (int i = 0; i < RB; i++) begin
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; wdata = pat(r, i, seed);
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] s;
    status(s);
    check("R1 status", RBIT'(s), RBIT'(8'h00));
    check("R1 outputs", RBIT'({busy, ana, boot}), '0);
    check("R1 valid", RBIT'(valid), '0);
    sel = 1'b0; #0.1;
    check("R9 sel0 read", RBIT'(rdata), '0);
  endtask

  task automatic t_ignored();
    logic [7:0] s;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sel = 1'b1; wr = 1'b1; wdata = 8'hA5;
    end
    @(negedge clk); wr = 1'b0;
    status(s);
    check("R10 status after stray data", RBIT'(s), '0);
    check("R10 valid after stray data", RBIT'(valid), '0);
    cmd(8'h55);
    status(s);
    check("R8 unknown command ignored", RBIT'(s), '0);
  endtask

  task automatic t_row_timing();
    logic [7:0] s;
    int hi = 0;
    cmd(8'h02);
    status(s);
    check("R3 load mode bit", RBIT'(s), RBIT'(8'h02));
    push_row(0, 0);
    // now at the negedge after the final accepting edge
    for (int k = 0; k < CC; k++) begin
      if (busy) hi++;
      if (k == 0) begin
        status(s);
        check("R9 busy bit", RBIT'(s[0]), RBIT'(1'b1));
        check("R4 no commit while busy", RBIT'(valid[0]), '0);
      end
      @(negedge clk);
    end
    check("R4 busy length", RBIT'(hi), RBIT'(CC));
    check("R4 busy fell", RBIT'(busy), '0);
    check("R4 valid row0", RBIT'(valid), RBIT'(1));
    raddr = '0; #0.1;
    check("R10 R4 row0 contents", rrow, exp_row(0, 0));
  endtask

  task automatic t_overrun();
    logic [7:0] s;
    cmd(8'h02);
    push_row(0, 1);
    check("R6 busy before drop", RBIT'(busy), RBIT'(1'b1));
    sel = 1'b1; wr = 1'b1; wdata = 8'hEE;
    @(negedge clk); wr = 1'b0;
    status(s);
    check("R6 overrun set", RBIT'(s[3]), RBIT'(1'b1));
    wait_idle();
    push_row(1, 1);
    wait_idle();
    raddr = PW'(1); #0.1;
    check("R6 dropped byte absent", rrow, exp_row(1, 1));
    status(s);
    check("R6 overrun sticky", RBIT'(s[3]), RBIT'(1'b1));
    cmd(8'h02);
    status(s);
    check("R6 load cmd keeps overrun", RBIT'(s[3]), RBIT'(1'b1));
  endtask

  task automatic t_analog_softrst();
    logic [7:0] s;
    cmd(8'h10);
    status(s);
    check("R8 analog status", RBIT'(s[4]), RBIT'(1'b1));
    check("R8 enables", RBIT'({ana, boot}), RBIT'(2'b11));
    cmd(8'h01);
    status(s);
    check("R2 status cleared", RBIT'(s), '0);
    check("R2 valid cleared", RBIT'(valid), '0);
    check("R2 enables cleared", RBIT'({ana, boot}), '0);
  endtask

  task automatic t_full_image();
    logic [7:0] s;
    int stalls_ok = 1;
    cmd(8'h02);
    for (int r = 0; r < NR; r++) begin
      push_row(r, 2);
      wait_idle();
    end
    status(s);
    check("R7 done set load clear", RBIT'(s[2:1]), RBIT'(2'b10));
    check("R5 no overrun", RBIT'(s[3]), '0);
    check("R5 all valid", RBIT'(valid), {RBIT{1'b0}} | {NR{1'b1}});
    for (int r = 0; r < NR; r++) begin
      raddr = PW'(r); #0.1;
      if (rrow !== exp_row(r, 2)) stalls_ok = 0;
    end
    check("R5 image contents", RBIT'(stalls_ok), RBIT'(1));
    push_row(0, 9);
    repeat (CC + 2) @(negedge clk);
    raddr = '0; #0.1;
    check("R7 data after done ignored", rrow, exp_row(0, 2));
    check("R7 no busy after done", RBIT'(busy), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ignored();
    t_row_timing();
    t_overrun();
    t_analog_softrst();
    t_full_image();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule